// File: doc/BRIEF.md
# CIC Decimator with Gain Offset

This block is a five-stage cascaded integrator-comb decimator for one stream of real, signed samples. Each accepted input passes through a coarse gain shifter that adds 6 dB per code step. It then enters a chain of five wrapping integrators, 40 bits wide. A decimation counter picks one integrator result in every R accepted inputs. That result passes through five combs, and an output shifter normalises its level before a 16-bit slice is presented with a one-cycle valid strobe.

The coarse gain code allows the analog front end to switch in attenuation while the filter output level stays the same. Each code step uses one bit of the 40-bit headroom, so the largest safe decimation becomes smaller as the code rises. The decimation counter reloads from a 6-bit field that holds R-1. An external sync pulse can also reload it when its enable is set, so that several channels decimate in phase.

Top module: `cicg_decimator`

## Requirements
- R1: While reset is active, and until the first decimated result exists, `out_valid_o` is 0 and `out_data_o` is 0.
- R2: An accepted sample is sign-extended to 40 bits and shifted left by `gain_code_i` places, so each code step doubles it (+6 dB) and codes 0..7 give 0..42 dB.
- R3: On each accepted sample, integrator 0 adds the shifted sample and integrator k (k = 1..4) adds the value that integrator k-1 held before this update. All arithmetic wraps modulo 2^40. Cycles with `in_valid_i` low change nothing.
- R4: An internal counter is cleared by reset. When a sample is accepted while the counter is 0 and no sync hit is present, a decimation takes place and the counter loads `dec_preload_i` (R-1). Any other accepted sample decrements the counter. So outputs are spaced R = preload+1 accepted samples apart.
- R5: At a decimation the comb chain takes the value integrator 4 held before that cycle's update. Comb k outputs its input minus the input it received at the previous decimation (differential delay 1), with wraparound.
- R6: The comb result is shifted arithmetically right by 15 - `shift_gain_i` places and truncated. `out_data_o` takes bits 24 down to 9 of that value and holds it until the next decimation.
- R7: `out_valid_o` is high for exactly the one cycle after each decimating input. It is never high unless a sample was accepted in the cycle before.
- R8: When `sync_in_i` and `sync_en_i` are both high in a cycle, the counter loads `dec_preload_i` and no decimation happens in that cycle, even if a sample is accepted and the counter is 0. The next output follows the R-th accepted sample after the sync cycle.
- R9: When `sync_en_i` is low, `sync_in_i` has no effect on the counter or on the outputs.
- R10: The first accepted sample after reset causes a decimation, because the counter starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid_i | input | 1 | Sample strobe |
| in_data_i | input | 14 | Signed input sample |
| gain_code_i | input | 3 | Coarse gain offset, 6 dB per step |
| shift_gain_i | input | 4 | Output normalising shift, 0..15 |
| dec_preload_i | input | 6 | Decimation factor minus one |
| sync_in_i | input | 1 | External counter reload pulse |
| sync_en_i | input | 1 | Enables the external reload |
| out_valid_o | output | 1 | One-cycle strobe for a decimated result |
| out_data_o | output | 16 | Decimated, normalised result |

## Verification
A sync hit and a counter wrap can arrive in the same cycle. When they collide, the reload wins and the decimation that would have happened is dropped. The bench provokes this in two ways: with random sync pulses over long runs where valid inputs are dense and the preload is small, and with a directed case that raises sync on the exact input where the counter is 0. It judges the result by checking that no strobe appears in the next cycle and that the following output comes only after R further accepted samples.

// File: rtl/cicg_pkg.sv
package cicg_pkg;
  localparam int unsigned CICG_IN_W    = 14;
  localparam int unsigned CICG_ACC_W   = 40;
  localparam int unsigned CICG_STAGES  = 5;
  localparam int unsigned CICG_GAIN_W  = 3;
  localparam int unsigned CICG_SG_W    = 4;
  localparam int unsigned CICG_PRE_W   = 6;
  localparam int unsigned CICG_OUT_W   = 16;
endpackage

// File: rtl/cicg_in_shift.sv
module cicg_in_shift #(
  parameter int unsigned IN_W   = 14,
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned GAIN_W = 3
) (
  input  logic [IN_W-1:0]   sample_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [ACC_W-1:0]  shifted_o
);
  localparam int unsigned EXT_W = ACC_W - IN_W;

  logic [ACC_W-1:0] ext;

  always_comb begin
    ext       = {{EXT_W{sample_i[IN_W-1]}}, sample_i};
    shifted_o = ext << gain_i;
  end
endmodule

// File: rtl/cicg_integ_chain.sv
module cicg_integ_chain #(
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned STAGES = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] din_i,
  output logic [ACC_W-1:0] dout_o
);
  logic [ACC_W-1:0] acc_q [STAGES];
  logic [ACC_W-1:0] acc_d [STAGES];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_comb acc_d[k] = acc_q[k] + din_i;
      end else begin : g_rest
        always_comb acc_d[k] = acc_q[k] + acc_q[k-1];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          acc_q[k] <= '0;
        end else if (en_i) begin
          acc_q[k] <= acc_d[k];
        end
      end
    end
  endgenerate

  assign dout_o = acc_q[STAGES-1];
endmodule

// File: rtl/cicg_dec_ctrl.sv
module cicg_dec_ctrl #(
  parameter int unsigned PRE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [PRE_W-1:0] preload_i,
  input  logic             sync_in_i,
  input  logic             sync_en_i,
  output logic             take_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;
  logic             sync_hit;
  logic             at_zero;

  always_comb begin
    sync_hit = sync_in_i & sync_en_i;
    at_zero  = (cnt_q == '0);
    take_o   = in_valid_i & ~sync_hit & at_zero;
    cnt_d    = cnt_q;
    if (sync_hit) begin
      cnt_d = preload_i;
    end else if (in_valid_i) begin
      cnt_d = at_zero ? preload_i : (cnt_q - 1'b1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/cicg_comb_out.sv
module cicg_comb_out #(
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned STAGES = 5,
  parameter int unsigned SG_W   = 4,
  parameter int unsigned OUT_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [ACC_W-1:0] din_i,
  input  logic [SG_W-1:0]  shift_gain_i,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] out_data_o
);
  localparam int unsigned SG_MAX    = (1 << SG_W) - 1;
  localparam int unsigned SLICE_LSB = ACC_W - SG_MAX - OUT_W;
  localparam logic [SG_W-1:0] SG_TOP = SG_W'(SG_MAX);

  logic [ACC_W-1:0] stage_v [STAGES+1];
  logic [ACC_W-1:0] dly_q   [STAGES];
  logic [SG_W-1:0]  shamt;
  logic [ACC_W-1:0] scaled;
  logic [OUT_W-1:0] data_d;

  assign stage_v[0] = din_i;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_comb
      always_comb stage_v[k+1] = stage_v[k] - dly_q[k];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          dly_q[k] <= '0;
        end else if (take_i) begin
          dly_q[k] <= stage_v[k];
        end
      end
    end
  endgenerate

  always_comb begin
    shamt  = SG_TOP - shift_gain_i;
    scaled = ACC_W'($signed(stage_v[STAGES]) >>> shamt);
    data_d = scaled[SLICE_LSB +: OUT_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= take_i;
      if (take_i) begin
        out_data_o <= data_d;
      end
    end
  end
endmodule

// File: rtl/cicg_decimator.sv
module cicg_decimator
  import cicg_pkg::*;
#(
  parameter int unsigned IN_W   = CICG_IN_W,
  parameter int unsigned ACC_W  = CICG_ACC_W,
  parameter int unsigned STAGES = CICG_STAGES,
  parameter int unsigned GAIN_W = CICG_GAIN_W,
  parameter int unsigned SG_W   = CICG_SG_W,
  parameter int unsigned PRE_W  = CICG_PRE_W,
  parameter int unsigned OUT_W  = CICG_OUT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [IN_W-1:0]   in_data_i,
  input  logic [GAIN_W-1:0] gain_code_i,
  input  logic [SG_W-1:0]   shift_gain_i,
  input  logic [PRE_W-1:0]  dec_preload_i,
  input  logic              sync_in_i,
  input  logic              sync_en_i,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  out_data_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic [ACC_W-1:0] shifted;
  logic [ACC_W-1:0] integ_out;
  logic             take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  cicg_in_shift #(.IN_W(IN_W), .ACC_W(ACC_W), .GAIN_W(GAIN_W)) u_shift (
    .sample_i  (in_data_i),
    .gain_i    (gain_code_i),
    .shifted_o (shifted)
  );

  cicg_integ_chain #(.ACC_W(ACC_W), .STAGES(STAGES)) u_integ (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .en_i   (in_valid_i),
    .din_i  (shifted),
    .dout_o (integ_out)
  );

  cicg_dec_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .in_valid_i (in_valid_i),
    .preload_i  (dec_preload_i),
    .sync_in_i  (sync_in_i),
    .sync_en_i  (sync_en_i),
    .take_o     (take)
  );

  cicg_comb_out #(.ACC_W(ACC_W), .STAGES(STAGES), .SG_W(SG_W), .OUT_W(OUT_W)) u_comb (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_int),
    .take_i       (take),
    .din_i        (integ_out),
    .shift_gain_i (shift_gain_i),
    .out_valid_o  (out_valid_o),
    .out_data_o   (out_data_o)
  );
endmodule

// File: rtl/cicg_decimator_chk.sv
module cicg_decimator_chk #(
  parameter int unsigned OUT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             sync_in_i,
  input logic             sync_en_i,
  input logic             out_valid_o,
  input logic [OUT_W-1:0] out_data_o
);
  // R7: a strobe always follows an accepted sample
  a_r7_strobe_after_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i));

  // R8: an enabled sync suppresses the decimation of its cycle
  a_r8_sync_blocks_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_in_i && sync_en_i) |=> !out_valid_o);

  // R3: idle cycles produce no result
  a_r3_idle_no_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  // R6: result holds between decimations
  a_r6_data_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_data_o));
endmodule

bind cicg_decimator cicg_decimator_chk #(.OUT_W(OUT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .sync_in_i   (sync_in_i),
  .sync_en_i   (sync_en_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o)
);

// File: tb/cicg_decimator_tb.sv
module cicg_decimator_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [13:0] in_data;
  logic [2:0]  gain_code;
  logic [3:0]  shift_gain;
  logic [5:0]  preload;
  logic        sync_in;
  logic        sync_en;
  logic        out_valid;
  logic [15:0] out_data;

  cicg_decimator dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .in_valid_i    (in_valid),
    .in_data_i     (in_data),
    .gain_code_i   (gain_code),
    .shift_gain_i  (shift_gain),
    .dec_preload_i (preload),
    .sync_in_i     (sync_in),
    .sync_en_i     (sync_en),
    .out_valid_o   (out_valid),
    .out_data_o    (out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag = "R1";

  logic [39:0] m_int [5];
  logic [39:0] m_dly [5];
  int          m_cnt;
  logic        exp_valid;
  logic [15:0] exp_data;

  task automatic model_reset();
    for (int k = 0; k < 5; k++) begin
      m_int[k] = '0;
      m_dly[k] = '0;
    end
    m_cnt = 0;
    exp_valid = 1'b0;
    exp_data = '0;
  endtask

  // requirement-level model of one clock edge
  task automatic model_step(input logic v, input logic [13:0] x, input logic [2:0] ga,
                            input logic [3:0] sg, input logic [5:0] pre,
                            input logic si, input logic se);
    logic        hit;
    logic        tk;
    logic [39:0] c;
    logic [39:0] t;
    logic [39:0] sh;
    logic [39:0] ext;
    hit = si && se;
    tk  = v && !hit && (m_cnt == 0);
    exp_valid = tk;
    if (tk) begin
      c = m_int[4];
      for (int k = 0; k < 5; k++) begin
        t = c - m_dly[k];
        m_dly[k] = c;
        c = t;
      end
      sh = 40'($signed(c) >>> (15 - int'(sg)));
      exp_data = sh[24:9];
    end
    if (v) begin
      ext = {{26{x[13]}}, x};
      for (int k = 4; k > 0; k--) m_int[k] = m_int[k] + m_int[k-1];
      m_int[0] = m_int[0] + (ext << ga);
    end
    if (hit) m_cnt = int'(pre);
    else if (v) m_cnt = (m_cnt == 0) ? int'(pre) : m_cnt - 1;
  endtask

  task automatic compare();
    checks++;
    if (out_valid !== exp_valid) begin
      fails++;
      $display("FAIL %s out_valid actual=%0b expected=%0b", tag, out_valid, exp_valid);
    end
    checks++;
    if (out_data !== exp_data) begin
      fails++;
      $display("FAIL %s out_data actual=%h expected=%h", tag, out_data, exp_data);
    end
  endtask

  task automatic step(input logic v, input logic [13:0] x, input logic [2:0] ga,
                      input logic [3:0] sg, input logic [5:0] pre,
                      input logic si, input logic se);
    @(negedge clk);
    compare();
    in_valid = v; in_data = x; gain_code = ga; shift_gain = sg;
    preload = pre; sync_in = si; sync_en = se;
    model_step(v, x, ga, sg, pre, si, se);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, 4'd15, 6'd0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0; in_data = '0; gain_code = '0; shift_gain = 4'd15;
    preload = '0; sync_in = 1'b0; sync_en = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();
    rst_n = 1'b1;
    idle(4);
  endtask

  initial begin
    void'($urandom(32'h5eed_c1c0));
    do_reset();

    // R10: first accepted sample decimates at once; R2 gain code 3 on an impulse
    tag = "R10";
    step(1'b1, 14'd1, 3'd3, 4'd15, 6'd0, 1'b0, 1'b0);
    tag = "R2";
    for (int i = 0; i < 6; i++) step(1'b1, 14'd0, 3'd3, 4'd15, 6'd0, 1'b0, 1'b0);
    // R2: most negative sample with full gain offset
    for (int i = 0; i < 4; i++) step(1'b1, 14'h2000, 3'd7, 4'd15, 6'd0, 1'b0, 1'b0);

    // R4: decimation by 4, R6 smaller shift gain
    tag = "R4";
    for (int i = 0; i < 20; i++) step(1'b1, 14'(i * 37), 3'd2, 4'd9, 6'd3, 1'b0, 1'b0);

    // R3: gaps in the valid strobe change nothing
    tag = "R3";
    for (int i = 0; i < 20; i++) step(1'(i % 3 == 0), 14'(i * 11), 3'd1, 4'd12, 6'd2, 1'b0, 1'b0);

    // R9: sync without enable is ignored, even on the wrapping input
    tag = "R9";
    for (int i = 0; i < 12; i++) step(1'b1, 14'd100, 3'd0, 4'd15, 6'd2, 1'b1, 1'b0);

    // R8: sync collides with a counter wrap; output suppressed, next after R inputs
    tag = "R8";
    do_reset();
    tag = "R8";
    step(1'b1, 14'd5, 3'd0, 4'd15, 6'd3, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b1, 14'd5, 3'd0, 4'd15, 6'd3, 1'b0, 1'b1);
    step(1'b0, 14'd0, 3'd0, 4'd15, 6'd3, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b1, 14'd9, 3'd0, 4'd15, 6'd3, 1'b0, 1'b1);

    // R5 R6 R7: random mix with occasional sync collisions
    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      logic v;
      logic si;
      logic [5:0] pre;
      v   = ($urandom_range(3) != 0);
      si  = ($urandom_range(15) == 0);
      pre = 6'($urandom_range(5));
      if (i % 500 == 250) tag = "R7";
      if (i % 500 == 0) tag = "R6";
      step(v, 14'($urandom), 3'($urandom_range(7)), 4'($urandom_range(15)), pre, si, 1'($urandom_range(1)));
    end

    // R4: largest preload, R = 64
    tag = "R4";
    for (int i = 0; i < 140; i++) step(1'b1, 14'($urandom), 3'd0, 4'd4, 6'd63, 1'b0, 1'b0);
    idle(2);
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule